// File: doc/BRIEF.md
# GPIO Pin Event Interrupt Front End

This block turns the eight input pins of one GPIO port into interrupt requests. Each pin has two configuration bits. One chooses between level sensing and edge sensing. The other chooses the active sense: low or falling, or high or rising. An edge that occurs on an enabled pin is held in a per-pin latch until software acknowledges it. A level-sensed pin stays pending for as long as its input matches the selected level.

The pending bits of all pins form a status byte, and their OR drives the port interrupt line. Every pin input passes through a two-flop synchronizer. After that, an optional per-pin filter can be switched on: it forwards a changed input only once the input has held steady over four consecutive sample strobes. Software reaches the configuration through byte-wide registers on a simple write/read bus. Software produces both-edge behaviour by flipping a pin's sense bit after each event, so the hardware detects one edge direction only.

Top module: `pin_event_ctl`

## Requirements
- R1: After reset all configuration registers read 0, no edge is latched, `statusByte` is 0 and `irqOut` is 0.
- R2: Bit i of every register belongs to pin i. The kind register is at address 0x00, the sense register at 0x04, the enable register at 0x0C and the filter register at 0x18, and each reads back the value last written. A read of 0x10 returns the status byte. A read of the acknowledge address 0x08 returns 0.
- R3: A pin whose kind bit is 0 is level sensed. It is pending while its synchronized input equals its sense bit (0 = low, 1 = high), and it stops being pending once the input differs.
- R4: A pin whose kind bit is 1 is edge sensed: sense 1 selects rising edges and sense 0 selects falling edges. A detected edge is latched, and the pin stays pending after the input returns to its old level.
- R5: Writing a byte to the acknowledge address clears the edge latch of each pin whose bit is 1. Latches of pins whose bit is 0 are left unchanged.
- R6: A pin whose enable bit is 0 is never pending. An edge that occurs while its enable bit is 0 is not latched, so setting the enable bit later reveals no event.
- R7: `irqOut` is 1 exactly when `statusByte` is non-zero.
- R8: With a pin's filter bit set, a changed input reaches detection only after it has been stable across 4 consecutive `sampleTick` pulses. A change that reverts before then is discarded. Pins without the filter bit are not delayed.
- R9: If an edge on a pin is detected in the same cycle as an acknowledge write with that pin's bit set, the edge stays latched.
- R10: A pin input change becomes visible on a level-sensed pin's status bit after the second rising clock edge, and not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinIn | input | 8 | Asynchronous pin inputs |
| sampleTick | input | 1 | Filter sample strobe, one cycle wide |
| wrEn | input | 1 | Register write strobe |
| addr | input | 5 | Register byte address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `addr` (combinational) |
| statusByte | output | 8 | Pending bit per pin |
| irqOut | output | 1 | Port interrupt request |

## Verification
The assertions check on every cycle that the following hold:
- an acknowledge write clears a latch unless an edge arrives in that same cycle, and such an edge always sets its latch;
- a latch never rises on a disabled pin;
- a filtered pin's value never changes in a cycle that follows no sample strobe;
- an enable write lands in the register.

Only the bench scenarios can show the remaining behaviour: the choice of sense and polarity per pin, that an edge stays pending after the input goes back, the exact two-edge synchronizer latency, and the filter discarding a glitch and accepting an input on exactly the fourth strobe.

// File: rtl/pin_event_pkg.sv
package pin_event_pkg;
  localparam int PIN_COUNT = 8;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] ADDR_KIND = 5'h00;
  localparam logic [ADDR_W-1:0] ADDR_SENSE = 5'h04;
  localparam logic [ADDR_W-1:0] ADDR_ACK = 5'h08;
  localparam logic [ADDR_W-1:0] ADDR_ENABLE = 5'h0C;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 5'h10;
  localparam logic [ADDR_W-1:0] ADDR_FILTER = 5'h18;

  typedef logic [PIN_COUNT-1:0] pinVec_t;

  // Configuration plus the one-cycle acknowledge strobe, handed to the datapath
  typedef struct packed {
    pinVec_t edgeSel;
    pinVec_t highSel;
    pinVec_t enable;
    pinVec_t filtEn;
    pinVec_t ackClr;
  } ctrlBus_t;
endpackage

// File: rtl/pin_event_ctrl.sv
module pin_event_ctrl
  import pin_event_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  pinVec_t           wrData,
  input  pinVec_t           statusIn,
  output pinVec_t           rdData,
  output ctrlBus_t          ctrlOut
);
  pinVec_t kindReg, senseReg, enableReg, filterReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kindReg <= '0;
      senseReg <= '0;
      enableReg <= '0;
      filterReg <= '0;
    end else if (wrEn) begin
      case (addr)
        ADDR_KIND:   kindReg <= wrData;
        ADDR_SENSE:  senseReg <= wrData;
        ADDR_ENABLE: enableReg <= wrData;
        ADDR_FILTER: filterReg <= wrData;
        default: ;
      endcase
    end
  end

  always_comb begin
    ctrlOut.edgeSel = kindReg;
    ctrlOut.highSel = senseReg;
    ctrlOut.enable = enableReg;
    ctrlOut.filtEn = filterReg;
    ctrlOut.ackClr = (wrEn && addr == ADDR_ACK) ? wrData : '0;
  end

  always_comb begin
    case (addr)
      ADDR_KIND:   rdData = kindReg;
      ADDR_SENSE:  rdData = senseReg;
      ADDR_ENABLE: rdData = enableReg;
      ADDR_FILTER: rdData = filterReg;
      ADDR_STATUS: rdData = statusIn;
      default:     rdData = '0;
    endcase
  end

  // R2: an enable write is visible in the register on the next cycle
  assert_enable_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_ENABLE) |=> (ctrlOut.enable == $past(wrData)));
endmodule

// File: rtl/pin_event_path.sv
module pin_event_path
  import pin_event_pkg::*;
#(
  parameter int DEB_COUNT = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  pinVec_t  pinIn,
  input  logic     sampleTick,
  input  ctrlBus_t ctrlIn,
  output pinVec_t  statusOut
);
  localparam int CNT_W = $clog2(DEB_COUNT + 1);

  pinVec_t syncStage [SYNC_STAGES];
  pinVec_t syncOut, filtVal, curVal, prevVal, riseHit, fallHit, edgeEv, latchQ, levelHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncStage[s] <= '0;
    end else begin
      syncStage[0] <= pinIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncStage[s] <= syncStage[s-1];
    end
  end
  assign syncOut = syncStage[SYNC_STAGES-1];

  for (genvar i = 0; i < PIN_COUNT; i++) begin : g_pin
    logic [CNT_W-1:0] stableCnt;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        filtVal[i] <= 1'b0;
        stableCnt <= '0;
      end else if (!ctrlIn.filtEn[i]) begin
        filtVal[i] <= syncOut[i];
        stableCnt <= '0;
      end else if (syncOut[i] == filtVal[i]) begin
        stableCnt <= '0;
      end else if (sampleTick) begin
        if (stableCnt == CNT_W'(DEB_COUNT - 1)) begin
          filtVal[i] <= syncOut[i];
          stableCnt <= '0;
        end else begin
          stableCnt <= stableCnt + 1'b1;
        end
      end
    end

    // R8: a filtered pin only moves on a sample strobe
    assert_filter_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
      (ctrlIn.filtEn[i] && $past(ctrlIn.filtEn[i]) && !$past(sampleTick)) |-> $stable(filtVal[i]));
    // R5: acknowledge clears the latch when no edge competes
    assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
      (ctrlIn.ackClr[i] && !edgeEv[i]) |=> !latchQ[i]);
    // R9: an enabled edge is always latched, even against an acknowledge
    assert_edge_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
      (edgeEv[i] && ctrlIn.enable[i]) |=> latchQ[i]);
    // R6: a latch never rises for a disabled pin
    assert_no_latch_disabled_R6: assert property (@(posedge clk) disable iff (!rstN)
      $rose(latchQ[i]) |-> $past(ctrlIn.enable[i]));
  end

  assign curVal = (ctrlIn.filtEn & filtVal) | (~ctrlIn.filtEn & syncOut);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevVal <= '0;
      latchQ <= '0;
    end else begin
      prevVal <= curVal;
      latchQ <= (latchQ & ~ctrlIn.ackClr) | (edgeEv & ctrlIn.enable);
    end
  end

  always_comb begin
    riseHit = curVal & ~prevVal;
    fallHit = ~curVal & prevVal;
    edgeEv = ctrlIn.edgeSel & ((ctrlIn.highSel & riseHit) | (~ctrlIn.highSel & fallHit));
    levelHit = ~ctrlIn.edgeSel & ~(curVal ^ ctrlIn.highSel);
    statusOut = ctrlIn.enable & ((ctrlIn.edgeSel & latchQ) | levelHit);
  end
endmodule

// File: rtl/pin_event_ctl.sv
module pin_event_ctl
  import pin_event_pkg::*;
#(
  parameter int DEB_COUNT = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        pinIn,
  input  logic              sampleTick,
  input  logic              wrEn,
  input  logic [4:0]        addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic [7:0]        statusByte,
  output logic              irqOut
);
  ctrlBus_t ctrlBus;

  pin_event_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .statusIn(statusByte), .rdData(rdData), .ctrlOut(ctrlBus)
  );

  pin_event_path #(.DEB_COUNT(DEB_COUNT), .SYNC_STAGES(SYNC_STAGES)) u_path (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .sampleTick(sampleTick),
    .ctrlIn(ctrlBus), .statusOut(statusByte)
  );

  assign irqOut = |statusByte;
endmodule

// File: tb/test_pin_event_ctl.sv
module test_pin_event_ctl;
  logic clk = 1'b0, rstN = 1'b0, sampleTick = 1'b0, wrEn = 1'b0;
  logic [7:0] pinIn = '0, wrData = '0, rdData, statusByte;
  logic [4:0] addr = '0;
  logic irqOut;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  pin_event_ctl i_pin_event_ctl (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .sampleTick(sampleTick), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .statusByte(statusByte), .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic regRead(input string tag, input logic [4:0] a, input logic [7:0] exp);
    @(negedge clk); addr = a; #1;
    check(tag, rdData, exp);
  endtask

  task automatic tick();
    @(negedge clk); sampleTick = 1'b1;
    @(negedge clk); sampleTick = 1'b0;
  endtask

  task automatic t_reset();
    settle(1);
    check("R1 status", statusByte, 8'h00);
    check("R1 irq", {7'd0, irqOut}, 8'h00);
    regRead("R1 kind", 5'h00, 8'h00);
    regRead("R1 enable", 5'h0C, 8'h00);
    regRead("R1 filter", 5'h18, 8'h00);
  endtask

  task automatic t_regmap();
    regWrite(5'h00, 8'hA5); regWrite(5'h04, 8'h3C); regWrite(5'h18, 8'h81);
    regRead("R2 kind", 5'h00, 8'hA5);
    regRead("R2 sense", 5'h04, 8'h3C);
    regRead("R2 filter", 5'h18, 8'h81);
    regRead("R2 ack reads 0", 5'h08, 8'h00);
    regRead("R2 status addr", 5'h10, 8'h00);
    regWrite(5'h00, 8'h00); regWrite(5'h04, 8'h00); regWrite(5'h18, 8'h00);
  endtask

  task automatic t_level();
    regWrite(5'h04, 8'h01); regWrite(5'h0C, 8'h03);
    settle(3);
    check("R3 low match", statusByte, 8'h02);
    check("R7 irq on", {7'd0, irqOut}, 8'h01);
    @(negedge clk); pinIn = 8'h01;
    @(negedge clk); check("R10 one edge", statusByte, 8'h02);
    @(negedge clk); check("R10 two edges", statusByte, 8'h03);
    pinIn = 8'h02; settle(3);
    check("R3 mismatch", statusByte, 8'h00);
    check("R7 irq off", {7'd0, irqOut}, 8'h00);
    regWrite(5'h0C, 8'h00);
  endtask

  task automatic t_edge();
    regWrite(5'h00, 8'hFF); regWrite(5'h04, 8'h0F);
    pinIn = 8'hF0; settle(4);
    regWrite(5'h08, 8'hFF); regWrite(5'h0C, 8'hFF); settle(2);
    check("R4 quiet", statusByte, 8'h00);
    pinIn = 8'h0F; settle(4);
    check("R4 rise and fall", statusByte, 8'hFF);
    pinIn = 8'hF0; settle(4);
    check("R4 held", statusByte, 8'hFF);
    regRead("R2 status read", 5'h10, 8'hFF);
    regWrite(5'h08, 8'h0F); settle(1);
    check("R5 partial ack", statusByte, 8'hF0);
    regWrite(5'h08, 8'hF0); settle(1);
    check("R5 full ack", statusByte, 8'h00);
  endtask

  task automatic t_disabled();
    regWrite(5'h0C, 8'h00);
    pinIn = 8'h0F; settle(4);
    regWrite(5'h0C, 8'hFF); settle(2);
    check("R6 edge while disabled", statusByte, 8'h00);
    regWrite(5'h0C, 8'h00); regWrite(5'h00, 8'h00); regWrite(5'h04, 8'h00);
    pinIn = 8'h00; settle(4);
    check("R6 level disabled", statusByte, 8'h00);
    regWrite(5'h0C, 8'h0F); settle(1);
    check("R6 per pin gate", statusByte, 8'h0F);
    regWrite(5'h0C, 8'h00);
  endtask

  task automatic t_race();
    regWrite(5'h00, 8'h01); regWrite(5'h04, 8'h01);
    regWrite(5'h08, 8'hFF); regWrite(5'h0C, 8'h01);
    pinIn = 8'h01; settle(4);
    check("R4 rise latched", statusByte, 8'h01);
    pinIn = 8'h00; settle(4);
    regWrite(5'h08, 8'h01); settle(1);
    check("R5 ack", statusByte, 8'h00);
    @(negedge clk); pinIn = 8'h01;
    @(posedge clk); @(posedge clk);
    @(negedge clk); wrEn = 1'b1; addr = 5'h08; wrData = 8'h01;
    @(negedge clk); wrEn = 1'b0;
    settle(1);
    check("R9 edge beats ack", statusByte, 8'h01);
    regWrite(5'h08, 8'h01); settle(1);
    check("R5 ack after race", statusByte, 8'h00);
    regWrite(5'h0C, 8'h00);
  endtask

  task automatic t_filter();
    pinIn = 8'h00;
    regWrite(5'h00, 8'h00); regWrite(5'h04, 8'h03); regWrite(5'h18, 8'h01);
    settle(4);
    regWrite(5'h0C, 8'h03); settle(1);
    check("R8 start", statusByte, 8'h00);
    pinIn = 8'h03; settle(4);
    check("R8 unfiltered pin passes", statusByte, 8'h02);
    tick(); tick(); tick();
    check("R8 three strobes", statusByte, 8'h02);
    pinIn = 8'h02; settle(4);
    pinIn = 8'h03; settle(4);
    tick(); tick(); tick();
    check("R8 glitch restarts count", statusByte, 8'h02);
    tick(); settle(1);
    check("R8 fourth strobe", statusByte, 8'h03);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_regmap();
    t_level();
    t_edge();
    t_disabled();
    t_race();
    t_filter();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #4000000;
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule